// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Scheduler

This block keeps an asynchronous DRAM with 512 rows and 9-bit multiplexed row addressing alive. After reset it holds every strobe idle for a long start-up pause. It then issues a fixed burst of refresh cycles and raises a ready flag. From then on it paces refresh from the system clock, so that one row is due every interval. That spreads the full 512-row sweep over the retention window (8 ms, one row every 15.6 µs or sooner).

An access controller asks for the memory with a level request and owns it while the grant is high. A due refresh never interrupts a granted access. At the next idle point a due refresh beats a new request. Refreshes that pile up behind a long access are counted, up to a parameter. One more interval after that sets an overrun flag and drops ready. Once the access is released, the wake-up burst runs again.

Each refresh cycle is either CAS-before-RAS, where the DRAM's own counter selects the row, or RAS-only, where a local 9-bit row counter drives the address bus. A mode input chooses between the two, and it is sampled at the start of every cycle. All timings (pause, interval, RAS low time, precharge, CAS setup and hold) are parameters counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_l_n and cas_h_n are high, and acc_gnt, ready and overrun are low.
- R2: For PAUSE_CYC clock edges after reset is released, no strobe goes low and no grant is given.
- R3: Right after the pause, exactly WAKE_N refresh cycles run back to back. Ready rises on the edge that ends the last of them.
- R4: In a CAS-before-RAS cycle, both CAS strobes are low for CAS_SETUP cycles before RAS falls. They stay low for the first CAS_HOLD cycles of the RAS_LOW-cycle low phase. Every refresh cycle ends with PRE_CYC cycles in which all strobes are high.
- R5: In a RAS-only cycle, both CAS strobes stay high, and addr holds the row counter for the whole RAS low phase.
- R6: The row counter on addr starts at 0 after reset. It advances by one at the end of every completed refresh cycle, in either mode, and wraps from 511 to 0.
- R7: One refresh becomes due every REF_INT cycles, counted from the end of the pause. While no access is held, each due refresh is issued at the next idle point.
- R8: A due refresh waits while acc_gnt is high. In the idle state a due refresh, or a pending overrun, takes precedence over acc_req. The grant is high one cycle after acc_req is seen in idle, and low one cycle after acc_req drops.
- R9: If a refresh falls due while MAX_POSTPONE refreshes are already pending, overrun goes high and ready goes low.
- R10: After an overrun, the next idle point starts a new WAKE_N-cycle burst. The pending count restarts from the refreshes due since that point. At the end of the burst, overrun clears and ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_cbr | input | 1 | 1 selects CAS-before-RAS, 0 selects RAS-only, sampled at each cycle start |
| acc_req | input | 1 | Access controller asks for the memory (level) |
| acc_gnt | output | 1 | Memory handed to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_l_n | output | 1 | Low-byte column strobe, active low |
| cas_h_n | output | 1 | High-byte column strobe, active low |
| addr | output | ROW_W | Multiplexed address, row counter value |
| ready | output | 1 | Memory usable for accesses |
| overrun | output | 1 | Refresh deadline exceeded |

## Verification
The strobes are first compared during the pause and the wake-up burst in CAS-before-RAS mode. This separates the burst length and the ready timing from the steady pacing that follows. Short access requests of varying length and spacing then land on every phase of the refresh pacing. This shows whether a due refresh is held back during a grant and wins at the idle point. A long quiet stretch in RAS-only mode runs the row counter through its 511-to-0 wrap on the address bus. Finally, an access held for several intervals forces an overrun, and mode changes mixed into later traffic show that the mode is taken per cycle.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W        = 9,
  parameter int PAUSE_CYC    = 10_000_000,
  parameter int REF_INT      = 1560,
  parameter int RAS_LOW      = 5,
  parameter int PRE_CYC      = 4,
  parameter int CAS_SETUP    = 1,
  parameter int CAS_HOLD     = 2,
  parameter int WAKE_N       = 8,
  parameter int MAX_POSTPONE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_cbr,
  input  logic             acc_req,
  output logic             acc_gnt,
  output logic             ras_n,
  output logic             cas_l_n,
  output logic             cas_h_n,
  output logic [ROW_W-1:0] addr,
  output logic             ready,
  output logic             overrun
);
  localparam int TW = $clog2(PAUSE_CYC + RAS_LOW + PRE_CYC + CAS_SETUP + 1);
  localparam int WW = $clog2(WAKE_N + 1);
  localparam int PW = $clog2(MAX_POSTPONE + 1);
  localparam int IW = $clog2(REF_INT + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_ACC, S_CSU, S_RLOW, S_PRE} st_t;

  st_t st;
  logic [TW-1:0]    tmr;
  logic [WW-1:0]    wake_left;
  logic [PW-1:0]    pend;
  logic [IW-1:0]    ivl;
  logic [ROW_W-1:0] row;
  logic             cbr, in_wake, woke;

  wire tick      = (st != S_PAUSE) && (ivl == IW'(REF_INT - 1));
  wire cyc_end   = (st == S_PRE) && (tmr == TW'(PRE_CYC - 1));
  wire burst_end = cyc_end && in_wake && (wake_left == WW'(1));
  wire dec       = cyc_end && !in_wake;
  wire wake_go   = (st == S_IDLE) && overrun;

  assign acc_gnt = (st == S_ACC);
  assign ras_n   = (st != S_RLOW);
  assign cas_l_n = !((st == S_CSU) || ((st == S_RLOW) && cbr && (tmr < TW'(CAS_HOLD))));
  assign cas_h_n = cas_l_n;
  assign addr    = row;
  assign ready   = woke && !overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PAUSE; tmr <= '0; cbr <= 1'b0;
      in_wake <= 1'b0; wake_left <= '0; row <= '0;
    end else begin
      case (st)
        S_PAUSE:
          if (tmr == TW'(PAUSE_CYC - 1)) begin
            st <= use_cbr ? S_CSU : S_RLOW; cbr <= use_cbr; tmr <= '0;
            in_wake <= 1'b1; wake_left <= WW'(WAKE_N);
          end else tmr <= tmr + 1'b1;
        S_IDLE:
          if (overrun) begin
            st <= use_cbr ? S_CSU : S_RLOW; cbr <= use_cbr; tmr <= '0;
            in_wake <= 1'b1; wake_left <= WW'(WAKE_N);
          end else if (pend != '0) begin
            st <= use_cbr ? S_CSU : S_RLOW; cbr <= use_cbr; tmr <= '0;
          end else if (acc_req) st <= S_ACC;
        S_ACC:
          if (!acc_req) st <= S_IDLE;
        S_CSU:
          if (tmr == TW'(CAS_SETUP - 1)) begin st <= S_RLOW; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_RLOW:
          if (tmr == TW'(RAS_LOW - 1)) begin st <= S_PRE; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        S_PRE:
          if (cyc_end) begin
            row <= row + 1'b1;
            if (in_wake && wake_left != WW'(1)) begin
              wake_left <= wake_left - 1'b1;
              st <= use_cbr ? S_CSU : S_RLOW; cbr <= use_cbr; tmr <= '0;
            end else begin
              in_wake <= 1'b0; st <= S_IDLE;
            end
          end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl <= '0;
    else if (st != S_PAUSE) ivl <= tick ? '0 : ivl + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; overrun <= 1'b0; woke <= 1'b0;
    end else begin
      if (wake_go) pend <= tick ? PW'(1) : '0;
      else if (tick && !dec) begin
        if (pend == PW'(MAX_POSTPONE)) overrun <= 1'b1;
        else pend <= pend + 1'b1;
      end else if (dec && !tick) pend <= pend - 1'b1;
      if (burst_end) begin
        overrun <= 1'b0; woke <= 1'b1;
      end
    end
  end
endmodule

module dram_refresh_sched_chk #(
  parameter int ROW_W   = 9,
  parameter int PRE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_gnt,
  input logic             ras_n,
  input logic             cas_l_n,
  input logic             cas_h_n,
  input logic [ROW_W-1:0] addr,
  input logic             ready,
  input logic             overrun
);
  // R4
  cbr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n) && !cas_l_n) |-> $past(!cas_l_n && !cas_h_n));
  // R5
  row_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(addr));
  // R8
  grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ras_n && cas_l_n && cas_h_n));
  // R8
  grant_start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_gnt) |-> ready);
  // R9
  overrun_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !ready);
  // R4
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && PRE_CYC > 1) |=> ras_n);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W), .PRE_CYC(PRE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_gnt(acc_gnt), .ras_n(ras_n), .cas_l_n(cas_l_n),
  .cas_h_n(cas_h_n), .addr(addr), .ready(ready), .overrun(overrun));

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int ROW_W = 9, PAUSE = 50, INTV = 60, RLOW = 4, PRE = 3;
  localparam int CSU = 1, HOLD = 2, WAKE = 8, MAXP = 3;

  logic clk = 1'b0, rst_n = 1'b0, use_cbr = 1'b1, acc_req = 1'b0;
  logic acc_gnt, ras_n, cas_l_n, cas_h_n, ready, overrun;
  logic [ROW_W-1:0] addr;

  dram_refresh_sched #(.ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .REF_INT(INTV), .RAS_LOW(RLOW),
    .PRE_CYC(PRE), .CAS_SETUP(CSU), .CAS_HOLD(HOLD), .WAKE_N(WAKE), .MAX_POSTPONE(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .use_cbr(use_cbr), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .ras_n(ras_n), .cas_l_n(cas_l_n), .cas_h_n(cas_h_n), .addr(addr), .ready(ready),
    .overrun(overrun));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: each refresh cycle is a queue of {ras_n,cas_n} codes
  int q[$];
  int m_phase, m_cnt, m_ivl, m_run, m_pend, m_ovr, m_woke, m_wake, m_row, m_cur;

  task automatic push_cycle();
    if (use_cbr) begin
      for (int i = 0; i < CSU; i++) q.push_back(2);
      for (int i = 0; i < RLOW; i++) q.push_back(i < HOLD ? 0 : 1);
    end else
      for (int i = 0; i < RLOW; i++) q.push_back(1);
    for (int i = 0; i < PRE; i++) q.push_back(3);
    m_cur = q.pop_front();
    m_phase = 3;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_phase = 0; m_cnt = 0; m_ivl = 0; m_run = 0; m_pend = 0; m_ovr = 0;
      m_woke = 0; m_wake = 0; m_row = 0; m_cur = 3;
    end else begin
      int o_pend, o_ovr, tick, dec, wgo, bend, nrun;
      o_pend = m_pend; o_ovr = m_ovr; nrun = m_run;
      tick = (m_run != 0 && m_ivl == INTV - 1);
      dec = 0; wgo = 0; bend = 0;
      case (m_phase)
        0: begin
          m_cnt++;
          if (m_cnt == PAUSE) begin nrun = 1; m_wake = WAKE; push_cycle(); end
        end
        1: begin
          if (o_ovr != 0) begin wgo = 1; m_wake = WAKE; push_cycle(); end
          else if (o_pend > 0) push_cycle();
          else if (acc_req) m_phase = 2;
        end
        2: if (!acc_req) m_phase = 1;
        default: begin
          if (q.size() > 0) m_cur = q.pop_front();
          else begin
            m_row = (m_row + 1) % (1 << ROW_W);
            if (m_wake > 0) begin
              m_wake--;
              if (m_wake == 0) begin bend = 1; m_phase = 1; m_cur = 3; end
              else push_cycle();
            end else begin dec = 1; m_phase = 1; m_cur = 3; end
          end
        end
      endcase
      if (m_run != 0) m_ivl = tick ? 0 : m_ivl + 1;
      m_run = nrun;
      if (wgo) m_pend = tick;
      else if (tick && !dec) begin
        if (o_pend == MAXP) m_ovr = 1; else m_pend++;
      end else if (dec && !tick) m_pend--;
      if (bend) begin m_ovr = 0; m_woke = 1; end
    end
  end

  int prev_addr = 0, wrap_seen = 0, pause_falls = 0, ovr_seen = 0, cyc = 0;

  always @(negedge clk) if (rst_n && !done) begin
    cyc++;
    chk(ras_n == m_cur[1], "R4 R5 ras_n", ras_n, m_cur[1]);
    chk(cas_l_n == m_cur[0] && cas_h_n == m_cur[0], "R4 R5 cas", {cas_h_n, cas_l_n}, {2{m_cur[0]}});
    chk(addr == m_row, "R6 addr", addr, m_row);
    chk(acc_gnt == (m_phase == 2), "R8 acc_gnt", acc_gnt, m_phase == 2);
    chk(ready == (m_woke != 0 && m_ovr == 0), "R3 R10 ready", ready, m_woke != 0 && m_ovr == 0);
    chk(overrun == (m_ovr != 0), "R9 overrun", overrun, m_ovr);
    if (cyc <= PAUSE && (!ras_n || !cas_l_n || acc_gnt)) pause_falls++;   // R2
    if (overrun) ovr_seen = 1;
    if (!ras_n && cas_l_n && addr == 0 && prev_addr == (1 << ROW_W) - 1) wrap_seen = 1;
    if (!ras_n && cas_l_n) prev_addr = addr;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_l_n && cas_h_n, "R1 strobes", {ras_n, cas_l_n, cas_h_n}, 7);
    chk(!acc_gnt && !ready && !overrun, "R1 flags", {acc_gnt, ready, overrun}, 0);
    rst_n = 1'b1;
    acc_req = 1'b1;                         // R2 request during pause ignored
    repeat (PAUSE + 2) @(negedge clk);
    chk(pause_falls == 0, "R2 pause quiet", pause_falls, 0);
    acc_req = 1'b0;
    repeat (150) @(negedge clk);            // R3 wake burst
    chk(ready == 1'b1, "R3 ready after burst", ready, 1);
    for (int i = 0; i < 300; i++) begin     // R7 R8 mixed traffic
      acc_req = 1'b1;
      repeat ((i * 7) % 13 + 1) @(negedge clk);
      acc_req = 1'b0;
      repeat ((i * 5) % 4 + 1) @(negedge clk);
    end
    use_cbr = 1'b0;                         // R5 R6 long RAS-only stretch
    repeat (33000) @(negedge clk);
    chk(wrap_seen == 1, "R6 row wrap", wrap_seen, 1);
    acc_req = 1'b1;                         // R9 hold past the limit
    repeat (400) @(negedge clk);
    chk(overrun == 1'b1 && ovr_seen == 1, "R9 overrun set", overrun, 1);
    chk(ready == 1'b0, "R9 ready dropped", ready, 0);
    acc_req = 1'b0;
    repeat (120) @(negedge clk);            // R10 burst rerun
    chk(overrun == 1'b0 && ready == 1'b1, "R10 recovered", {overrun, ready}, 1);
    for (int i = 0; i < 200; i++) begin     // R4 mode switched per cycle
      use_cbr = i[0];
      acc_req = (i % 3) != 0;
      repeat (i % 9 + 2) @(negedge clk);
    end
    acc_req = 1'b0;
    repeat (100) @(negedge clk);
    finish_run();
  end
endmodule